// File: doc/BRIEF.md
# PTP Timing Pin Capture and Square-Wave Output

This block owns one bidirectional timing pin and works against a free-running 64-bit PTP time. In output mode it drives a square wave with a fixed 50% duty cycle: the pin stays low until the PTP time reaches a programmed absolute start time, then goes high and flips every half of a programmed period. In input mode it stamps every transition of the pin, rising or falling, with the PTP time. The stamp goes into a single capture register.

The capture path has no queue and raises no interrupt. A newer edge replaces the stored stamp, so software must poll at least twice as often as edges arrive. A sticky new-capture flag and an overrun flag tell software whether it kept up. Both flags are cleared by reading the upper stamp word. The incoming pin passes through a two-flop synchroniser. The stamp is corrected by a fixed latency, so it equals the PTP time presented on the first clock edge after the pin changed.

Software reaches the block through a simple word-addressed read/write bus. Reads are combinational.

The register map uses a 3-bit word address:
- 0 CTRL: bit0 is the direction (1 = output), bit1 is run.
- 1 START_L and 2 START_H hold the start time.
- 3 PERIOD holds the period in PTP time units; the half-period is PERIOD/2.
- 4 TS_L and 5 TS_H hold the stamp.
- 6 STAT: bit0 is new, bit1 is overrun.

Top module: `ptp_pin_unit`

## Requirements
- R1: After reset pin_o and pin_oe_o are 0, and registers 4 (TS_L), 5 (TS_H) and 6 (STAT) read 0.
- R2: pin_oe_o equals CTRL bit0. While CTRL bit0 is 0 (input mode), pin_o is 0.
- R3: With CTRL bit0 = 1 and bit1 = 1, pin_o stays low until the PTP time seen at a clock edge is at or past the 64-bit START value. It goes high after that edge.
- R4: Once started, pin_o flips each time the PTP time reaches the next deadline, spaced PERIOD/2 apart. High and low phases are therefore of equal length.
- R5: Writing CTRL bit1 = 0 drives pin_o low from the very next cycle.
- R6: In input mode both rising and falling pin edges load the capture register. The stamp equals the PTP time presented on the first clock edge after the pin changed.
- R7: There is a single capture register. A later edge overwrites it, so a pulse shorter than the poll interval leaves only its falling-edge stamp.
- R8: STAT bit0 (new) sets on every capture and clears on a read of address 5 (TS_H). A capture in the same cycle as that read wins.
- R9: STAT bit1 (overrun) sets when a capture arrives while new is still set. It clears with the same TS_H read.
- R10: A write to CTRL that changes bit0 clears the stamp and both flags, and forces run to 0.
- R11: In output mode, edges on pin_i are ignored: the stamp and the flags do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ptp_time_i | input | 64 | Current PTP time |
| pin_i | input | 1 | Pin level from the pad (asynchronous) |
| pin_o | output | 1 | Pin level driven in output mode |
| pin_oe_o | output | 1 | Pad output enable (1 = output mode) |
| bus_req_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 3 | Word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational on the address |

## Verification
A wrong deadline register shows up at pin_o within one half-period as an early or late flip. The bench compares every cycle of several start/period combinations against the ideal wave, so such a slip cannot pass unnoticed. A wrong synchroniser depth or latency constant shifts the stamp by a multiple of the PTP step. A broken flag update appears on the next STAT read, which follows each capture scenario within a few cycles.

// File: rtl/ptp_pin_pkg.sv
package ptp_pin_pkg;
  localparam int unsigned BUS_W = 32;
  localparam int unsigned ADR_W = 3;

  typedef enum logic [ADR_W-1:0] {
    A_CTRL    = 3'd0,
    A_START_L = 3'd1,
    A_START_H = 3'd2,
    A_PERIOD  = 3'd3,
    A_TS_L    = 3'd4,
    A_TS_H    = 3'd5,
    A_STAT    = 3'd6
  } reg_addr_e;

  localparam int unsigned CTRL_DIR = 0;
  localparam int unsigned CTRL_RUN = 1;
endpackage

// File: rtl/ptp_pin_sync.sv
module ptp_pin_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic edge_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign edge_o = sync_q[STAGES-1] ^ prev_q;
endmodule

// File: rtl/ptp_pin_capture.sv
module ptp_pin_capture #(
  parameter int unsigned TS_W = 64,
  parameter int unsigned LAT  = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [TS_W-1:0] ptp_time_i,
  input  logic            edge_i,
  input  logic            arm_i,
  input  logic            clr_i,
  input  logic            rd_i,
  output logic [TS_W-1:0] ts_o,
  output logic            new_o,
  output logic            ovr_o
);
  logic            cap;
  logic [TS_W-1:0] ts_q;
  logic            new_q, ovr_q;

  assign cap = edge_i & arm_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ts_q  <= '0;
      new_q <= 1'b0;
      ovr_q <= 1'b0;
    end else if (clr_i) begin
      ts_q  <= '0;
      new_q <= 1'b0;
      ovr_q <= 1'b0;
    end else if (cap) begin
      ts_q  <= ptp_time_i - TS_W'(LAT);
      new_q <= 1'b1;
      ovr_q <= new_q & ~rd_i;
    end else if (rd_i) begin
      new_q <= 1'b0;
      ovr_q <= 1'b0;
    end
  end

  assign ts_o  = ts_q;
  assign new_o = new_q;
  assign ovr_o = ovr_q;

  AST_OVR_WITH_NEW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_q |-> new_q); // R9
  AST_READ_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !cap) |=> (!new_q && !ovr_q)); // R8
  AST_OVR_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovr_q) |-> $past(new_q)); // R9
endmodule

// File: rtl/ptp_pin_wavegen.sv
module ptp_pin_wavegen #(
  parameter int unsigned TS_W = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [TS_W-1:0] ptp_time_i,
  input  logic            en_i,
  input  logic [TS_W-1:0] start_i,
  input  logic [TS_W-1:0] half_i,
  output logic            wave_o
);
  logic            running_q, pin_q;
  logic [TS_W-1:0] next_q;
  logic            due;

  assign due = (ptp_time_i >= next_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      running_q <= 1'b0;
      pin_q     <= 1'b0;
      next_q    <= '0;
    end else if (!en_i) begin
      running_q <= 1'b0;
      pin_q     <= 1'b0;
    end else if (!running_q) begin
      if (ptp_time_i >= start_i) begin
        running_q <= 1'b1;
        pin_q     <= 1'b1;
        next_q    <= start_i + half_i;
      end
    end else if (due) begin
      pin_q  <= ~pin_q;
      next_q <= next_q + half_i;
    end
  end

  assign wave_o = pin_q;

  AST_PRESTART_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !running_q |-> !pin_q); // R3
  AST_FLIP_ON_DEADLINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && running_q && due) |=> (pin_q != $past(pin_q))); // R4
endmodule

// File: rtl/ptp_pin_unit.sv
module ptp_pin_unit
  import ptp_pin_pkg::*;
#(
  parameter int unsigned TS_W     = 64,
  parameter int unsigned SYNC_STG = 2,
  parameter int unsigned LAT      = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TS_W-1:0]   ptp_time_i,
  input  logic              pin_i,
  output logic              pin_o,
  output logic              pin_oe_o,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [ADR_W-1:0]  bus_addr_i,
  input  logic [BUS_W-1:0]  bus_wdata_i,
  output logic [BUS_W-1:0]  bus_rdata_o
);
  localparam int unsigned HI_W = TS_W - BUS_W;

  logic              dir_q, run_q;
  logic [TS_W-1:0]   start_q;
  logic [BUS_W-1:0]  period_q;
  logic [TS_W-1:0]   half;
  logic              wr, rd_hi, mode_chg;
  logic              edge_s, wave;
  logic [TS_W-1:0]   ts;
  logic              ts_new, ts_ovr;

  assign wr       = bus_req_i & bus_we_i;
  assign rd_hi    = bus_req_i & ~bus_we_i & (bus_addr_i == A_TS_H);
  assign mode_chg = wr & (bus_addr_i == A_CTRL) & (bus_wdata_i[CTRL_DIR] != dir_q);
  assign half     = TS_W'(period_q >> 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q    <= 1'b0;
      run_q    <= 1'b0;
      start_q  <= '0;
      period_q <= '0;
    end else if (wr) begin
      case (bus_addr_i)
        A_CTRL: begin
          dir_q <= bus_wdata_i[CTRL_DIR];
          run_q <= mode_chg ? 1'b0 : bus_wdata_i[CTRL_RUN];
        end
        A_START_L: start_q[BUS_W-1:0]    <= bus_wdata_i;
        A_START_H: start_q[TS_W-1:BUS_W] <= bus_wdata_i[HI_W-1:0];
        A_PERIOD:  period_q              <= bus_wdata_i;
        default: ;
      endcase
    end
  end

  ptp_pin_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pin_i (pin_i),
    .edge_o(edge_s)
  );

  ptp_pin_capture #(.TS_W(TS_W), .LAT(LAT)) u_cap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ptp_time_i(ptp_time_i),
    .edge_i    (edge_s),
    .arm_i     (~dir_q),
    .clr_i     (mode_chg),
    .rd_i      (rd_hi),
    .ts_o      (ts),
    .new_o     (ts_new),
    .ovr_o     (ts_ovr)
  );

  ptp_pin_wavegen #(.TS_W(TS_W)) u_wave (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ptp_time_i(ptp_time_i),
    .en_i      (dir_q & run_q),
    .start_i   (start_q),
    .half_i    (half),
    .wave_o    (wave)
  );

  assign pin_oe_o = dir_q;
  assign pin_o    = wave & dir_q & run_q;

  always_comb begin
    bus_rdata_o = '0;
    case (bus_addr_i)
      A_CTRL:    bus_rdata_o = BUS_W'({run_q, dir_q});
      A_START_L: bus_rdata_o = start_q[BUS_W-1:0];
      A_START_H: bus_rdata_o = BUS_W'(start_q[TS_W-1:BUS_W]);
      A_PERIOD:  bus_rdata_o = period_q;
      A_TS_L:    bus_rdata_o = ts[BUS_W-1:0];
      A_TS_H:    bus_rdata_o = BUS_W'(ts[TS_W-1:BUS_W]);
      A_STAT:    bus_rdata_o = BUS_W'({ts_ovr, ts_new});
      default:   bus_rdata_o = '0;
    endcase
  end

  AST_IN_MODE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pin_oe_o |-> !pin_o); // R2
  AST_OUT_MODE_NO_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin_oe_o |=> $stable(ts)); // R11
  AST_MODE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_chg |=> (ts == '0 && !ts_new && !ts_ovr && !run_q)); // R10
endmodule

// File: tb/ptp_pin_unit_tb.sv
module ptp_pin_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] ptp = '0;
  logic        pin_in = 1'b0;
  logic        pin_out, pin_oe;
  logic        req = 1'b0, we = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  initial forever begin
    @(posedge clk);
    if (rst_n) ptp <= ptp + 64'd8;
  end

  ptp_pin_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ptp_time_i(ptp), .pin_i(pin_in),
    .pin_o(pin_out), .pin_oe_o(pin_oe), .bus_req_i(req), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata)
  );

  // {start offset, period, cycles to observe}
  localparam int unsigned NV = 4;
  localparam logic [31:0] VEC [NV][3] = '{
    '{32'd80,  32'd32, 32'd40},
    '{32'd96,  32'd16, 32'd30},
    '{32'd200, 32'd64, 32'd70},
    '{32'd88,  32'd48, 32'd50}
  };

  task automatic check(input string req_tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req_tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    logic [31:0] d;
    logic [63:0] s, t, p1, p2, p3, half;
    logic        exp_pin;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check("R1 pin_o", pin_out, 0);
    check("R1 pin_oe", pin_oe, 0);
    bus_rd(3'd4, d); check("R1 TS_L", d, 0);
    bus_rd(3'd5, d); check("R1 TS_H", d, 0);
    bus_rd(3'd6, d); check("R1 STAT", d, 0);

    // vector table: output waveform R3 R4 R5
    for (int v = 0; v < NV; v++) begin
      bus_wr(3'd0, 32'd1);
      check("R2 oe in output", pin_oe, 1);
      @(negedge clk);
      s = ptp + 64'(VEC[v][0]);
      half = 64'(VEC[v][1] >> 1);
      bus_wr(3'd1, s[31:0]);
      bus_wr(3'd2, s[63:32]);
      bus_wr(3'd3, VEC[v][1]);
      bus_wr(3'd0, 32'd3);
      for (int c = 0; c < int'(VEC[v][2]); c++) begin
        @(negedge clk);
        t = ptp - 64'd8;
        exp_pin = (t >= s) ? (((t - s) / half) % 2 == 0) : 1'b0;
        check((t < s) ? "R3 prestart" : "R4 wave", pin_out, exp_pin);
      end
      @(negedge clk);
      req = 1'b1; we = 1'b1; addr = 3'd0; wdata = 32'd1;
      @(negedge clk);
      req = 1'b0; we = 1'b0;
      check("R5 stop", pin_out, 0);
    end

    // R2 R10: back to input mode
    bus_wr(3'd0, 32'd0);
    check("R2 oe in input", pin_oe, 0);
    check("R2 pin low in input", pin_out, 0);

    // R6 rising edge
    @(negedge clk); pin_in = 1'b1; p1 = ptp;
    idle(5);
    bus_rd(3'd6, d); check("R8 new set", d, 1);
    bus_rd(3'd4, d); check("R6 rise TS_L", d, p1[31:0]);
    bus_rd(3'd5, d); check("R6 rise TS_H", d, p1[63:32]);
    bus_rd(3'd6, d); check("R8 new cleared", d, 0);

    // R6 falling edge
    @(negedge clk); pin_in = 1'b0; p2 = ptp;
    idle(5);
    bus_rd(3'd4, d); check("R6 fall TS_L", d, p2[31:0]);
    bus_rd(3'd5, d);

    // R7 R9 short pulse
    @(negedge clk); pin_in = 1'b1;
    @(negedge clk); pin_in = 1'b0; p3 = ptp;
    idle(5);
    bus_rd(3'd4, d); check("R7 fall survives", d, p3[31:0]);
    bus_rd(3'd6, d); check("R9 overrun", d, 3);
    bus_rd(3'd5, d);
    bus_rd(3'd6, d); check("R9 cleared", d, 0);

    // R10 mode change clears a fresh capture
    @(negedge clk); pin_in = 1'b1;
    idle(5);
    bus_rd(3'd6, d); check("R10 pre new", d, 1);
    bus_wr(3'd0, 32'd3);
    bus_rd(3'd6, d); check("R10 STAT clr", d, 0);
    bus_rd(3'd4, d); check("R10 TS clr", d, 0);
    bus_rd(3'd0, d); check("R10 run forced 0", d, 1);

    // R11 edges ignored in output mode
    @(negedge clk); pin_in = 1'b0;
    idle(3);
    @(negedge clk); pin_in = 1'b1;
    idle(5);
    bus_rd(3'd6, d); check("R11 STAT", d, 0);
    bus_rd(3'd4, d); check("R11 TS_L", d, 0);

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule